// File: doc/BRIEF.md
# Serial Configuration Stream Loader with Chain Pass-Through

This block takes a configuration bitstream one bit per configuration clock. It waits in a hunt state until it sees a four-bit start code, then reads a 24-bit length. The length is the number of configuration clocks the whole chain of devices needs. After that the block reads its own data frames and writes each one out with an address that counts up. It checks the framing of every frame.

A serial output feeds the next device in the chain. The start code and the length pass through to that output so that every device further down sees them. While the block takes its own frames, the output stays high, so no start bit can reach the next device. When the local frame store is full, later bits pass straight through. A framing fault pulls the active-low init line low and freezes the block. When the clock count reaches the length, the block raises a level that starts the device.

Top module: `cfg_chain_loader`

## Requirements
- R1: While hunting, the block looks for the bit order 0,0,1,0 (code 4'b0010, first bit received in the MSB). Idle high bits and any other pattern, such as 0,0,1,1, leave it hunting.
- R2: During the hunt and the header, `dout` repeats `din` one clock later. The header is the start code plus the 24 length bits.
- R3: The 24 bits after the start code form the length, sent MSB first.
- R4: A frame is one low start bit, then FRAME_W data bits (MSB first), then a check bit equal to the XOR of the data bits, then one high stop bit. Frames follow each other with no gap, and the first frame starts right after the last length bit.
- R5: A frame with no fault gives a one-clock `wr` pulse in the clock after its stop bit. In that clock, `wdata` holds the frame's data and `waddr` holds its index. The index starts at 0 after reset and goes up by one per frame.
- R6: While the block takes its own FRAMES frames, `dout` is held high.
- R7: Once FRAMES frames have been written, every later bit is repeated on `dout` one clock later.
- R8: Any of these is a framing fault: a high bit in the start position, a wrong check bit, or a low stop bit. From the clock after the faulty bit, `init_n` is low and stays low until reset. After that there are no writes, `dout` stays high and `startup` never rises.
- R9: The clock count starts at 1 on the first length bit. Idle and start-code clocks are not counted. In the clock after the bit whose count equals the length, `startup` goes high and stays high, and from then on `dout` is high.
- R10: During and right after reset, `dout` and `init_n` are high, and `wr` and `startup` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock, one stream bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial configuration data |
| dout | output | 1 | Serial output to the next device in the chain |
| init_n | output | 1 | Active low when a framing fault has been seen |
| wr | output | 1 | Frame write strobe |
| waddr | output | AW | Frame address, counting up |
| wdata | output | FRAME_W | Frame data |
| startup | output | 1 | Level that starts the device |

## Verification
The streams start with idle runs of random length. Some of them hold a near-miss code (0,0,1,1) in front of the real start code. The timing of `startup` then shows whether those idle and near-miss clocks were wrongly counted toward the length. The surplus after the local frames is random, including zero. With zero surplus, the last write and the rise of `startup` fall on the same clock. With surplus, bits that should be forwarded can be told apart from bits that should be held high. Faults are injected at each of the three frame positions (start, check, stop) in different frames. This shows that a fault stops the frame it is in, while the writes of earlier frames still go out.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    localparam int LEN_W = 24;
    localparam logic [3:0] START_CODE = 4'b0010;

    typedef enum logic [2:0] {
        S_HUNT,
        S_LEN,
        S_LOAD,
        S_PASS,
        S_ERR,
        S_DONE
    } ld_state_e;
endpackage

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int   W       = 8,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    generate
        if (W == 1) begin : g_one
            always_comb q_d = en ? din : q_q;
        end else begin : g_many
            always_comb q_d = en ? {q_q[W-2:0], din} : q_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= {W{RST_VAL}};
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/cfg_clk_cnt.sv
module cfg_clk_cnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = inc ? cnt_q + W'(1) : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q = cnt_q;
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
    import cfg_loader_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int FRAMES  = 4,
    parameter int AW      = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic               cclk,
    input  logic               rst_n,
    input  logic               din,
    output logic               dout,
    output logic               init_n,
    output logic               wr,
    output logic [AW-1:0]      waddr,
    output logic [FRAME_W-1:0] wdata,
    output logic               startup
);
    localparam int FL    = FRAME_W + 3;
    localparam int PMAX  = (FL > LEN_W) ? FL : LEN_W;
    localparam int BW    = $clog2(PMAX + 1);
    localparam int FCW   = $clog2(FRAMES + 1);
    localparam logic [BW-1:0]  P_DATA_LAST = BW'(FRAME_W);
    localparam logic [BW-1:0]  P_CHECK     = BW'(FRAME_W + 1);
    localparam logic [BW-1:0]  P_LEN_LAST  = BW'(LEN_W - 1);
    localparam logic [FCW-1:0] F_LAST      = FCW'(FRAMES - 1);

    typedef struct packed {
        ld_state_e      st;
        logic [BW-1:0]  pos;
        logic [FCW-1:0] fcnt;
        logic           par;
        logic           dout;
        logic           wr;
        logic [AW-1:0]  wa;
        logic           start;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0]         win_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] frm_q;
    logic               win_en, len_en, frm_en, cnt_inc;

    assign win_en  = (r_q.st == S_HUNT);
    assign len_en  = (r_q.st == S_LEN);
    assign frm_en  = (r_q.st == S_LOAD) && (r_q.pos != '0) && (r_q.pos <= P_DATA_LAST);
    assign cnt_inc = (r_q.st == S_LEN) || (r_q.st == S_LOAD) || (r_q.st == S_PASS);

    cfg_shift #(.W(3), .RST_VAL(1'b1)) u_win (
        .clk(cclk), .rst_n(rst_n), .en(win_en), .din(din), .q(win_q)
    );

    cfg_shift #(.W(LEN_W), .RST_VAL(1'b0)) u_len (
        .clk(cclk), .rst_n(rst_n), .en(len_en), .din(din), .q(len_q)
    );

    cfg_shift #(.W(FRAME_W), .RST_VAL(1'b0)) u_frm (
        .clk(cclk), .rst_n(rst_n), .en(frm_en), .din(din), .q(frm_q)
    );

    cfg_clk_cnt #(.W(LEN_W)) u_cnt (
        .clk(cclk), .rst_n(rst_n), .inc(cnt_inc), .q(cnt_q)
    );

    always_comb begin
        logic fault;
        r_d    = r_q;
        r_d.wr = 1'b0;
        fault  = 1'b0;
        unique case (r_q.st)
            S_HUNT: begin
                r_d.dout = din;
                if ({win_q, din} == START_CODE) begin
                    r_d.st  = S_LEN;
                    r_d.pos = '0;
                end
            end
            S_LEN: begin
                r_d.dout = din;
                if (r_q.pos == P_LEN_LAST) begin
                    r_d.st  = S_LOAD;
                    r_d.pos = '0;
                end else begin
                    r_d.pos = r_q.pos + BW'(1);
                end
            end
            S_LOAD: begin
                r_d.dout = 1'b1;
                if (r_q.pos == '0) begin
                    if (din) fault = 1'b1;
                    else begin
                        r_d.par = 1'b0;
                        r_d.pos = BW'(1);
                    end
                end else if (r_q.pos <= P_DATA_LAST) begin
                    r_d.par = r_q.par ^ din;
                    r_d.pos = r_q.pos + BW'(1);
                end else if (r_q.pos == P_CHECK) begin
                    if (din != r_q.par) fault = 1'b1;
                    else r_d.pos = r_q.pos + BW'(1);
                end else begin
                    if (!din) fault = 1'b1;
                    else begin
                        r_d.wr   = 1'b1;
                        r_d.wa   = AW'(r_q.fcnt);
                        r_d.fcnt = r_q.fcnt + FCW'(1);
                        r_d.pos  = '0;
                        if (r_q.fcnt == F_LAST) r_d.st = S_PASS;
                    end
                end
            end
            S_PASS: r_d.dout = din;
            default: r_d.dout = 1'b1;
        endcase

        if (fault) begin
            r_d.st   = S_ERR;
            r_d.dout = 1'b1;
        end else if (((r_q.st == S_LOAD) || (r_q.st == S_PASS)) &&
                     (cnt_q + LEN_W'(1) == len_q)) begin
            r_d.st    = S_DONE;
            r_d.start = 1'b1;
            r_d.dout  = 1'b1;
        end
    end

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= S_HUNT;
            r_q.dout  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout    = r_q.dout;
    assign init_n  = (r_q.st != S_ERR);
    assign wr      = r_q.wr;
    assign waddr   = r_q.wa;
    assign wdata   = frm_q;
    assign startup = r_q.start;
endmodule

// File: rtl/cfg_chain_loader_chk.sv
module cfg_chain_loader_chk (
    input logic cclk,
    input logic rst_n,
    input logic dout,
    input logic init_n,
    input logic wr,
    input logic startup
);
    AST_WR_SINGLE: assert property (@(posedge cclk) disable iff (!rst_n)
        wr |=> !wr); // R5
    AST_FAULT_STICKY: assert property (@(posedge cclk) disable iff (!rst_n)
        !init_n |=> !init_n); // R8
    AST_FAULT_QUIET: assert property (@(posedge cclk) disable iff (!rst_n)
        !init_n |-> (dout && !wr && !startup)); // R8
    AST_START_STICKY: assert property (@(posedge cclk) disable iff (!rst_n)
        startup |=> startup); // R9
    AST_START_QUIET: assert property (@(posedge cclk) disable iff (!rst_n)
        (startup && $past(startup)) |-> (dout && !wr)); // R9
endmodule

bind cfg_chain_loader cfg_chain_loader_chk u_chk (
    .cclk(cclk), .rst_n(rst_n), .dout(dout), .init_n(init_n),
    .wr(wr), .startup(startup)
);

// File: tb/test_cfg_chain_loader.sv
module test_cfg_chain_loader;
    localparam int FW = 8;
    localparam int NF = 4;
    localparam int AW = 2;
    localparam int FL = FW + 3;

    logic          cclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          din = 1'b1;
    logic          dout, init_n, wr, startup;
    logic [AW-1:0] waddr;
    logic [FW-1:0] wdata;

    int checks = 0;
    int errs = 0;
    bit finished = 1'b0;

    always #5 cclk = ~cclk;

    cfg_chain_loader #(.FRAME_W(FW), .FRAMES(NF), .AW(AW)) i_cfg_chain_loader (
        .cclk(cclk), .rst_n(rst_n), .din(din), .dout(dout), .init_n(init_n),
        .wr(wr), .waddr(waddr), .wdata(wdata), .startup(startup)
    );

    logic          sb[$];
    logic [FW-1:0] fdata[NF];

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int err_offset(int kind);
        return (kind == 1) ? 0 : (kind == 2) ? FW + 1 : FW + 2;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        din   = 1'b1;
        repeat (3) @(posedge cclk);
        #2;
        chk("R10 dout", int'(dout), 1);
        chk("R10 init_n", int'(init_n), 1);
        chk("R10 wr", int'(wr), 0);
        chk("R10 startup", int'(startup), 0);
        @(negedge cclk);
        rst_n = 1'b1;
    endtask

    // kind: 0 none, 1 start bit high, 2 check bit wrong, 3 stop bit low
    task automatic run(int idle, bit near_miss, int surplus, int extra, int kind, int efr);
        int hs, fr0, len, erri, fend;
        sb.delete();
        if (near_miss) begin
            sb.push_back(1'b0); sb.push_back(1'b0); sb.push_back(1'b1); sb.push_back(1'b1);
        end
        for (int i = 0; i < idle; i++) sb.push_back(1'b1);
        hs = sb.size();
        sb.push_back(1'b0); sb.push_back(1'b0); sb.push_back(1'b1); sb.push_back(1'b0);
        len = 24 + NF * FL + surplus;
        for (int i = 23; i >= 0; i--) sb.push_back(logic'((len >> i) & 1));
        fr0 = sb.size();
        fend = fr0 + NF * FL;
        for (int k = 0; k < NF; k++) begin
            logic p;
            fdata[k] = FW'($urandom);
            p = ^fdata[k];
            sb.push_back((kind == 1 && k == efr) ? 1'b1 : 1'b0);
            for (int i = FW - 1; i >= 0; i--) sb.push_back(fdata[k][i]);
            sb.push_back((kind == 2 && k == efr) ? ~p : p);
            sb.push_back((kind == 3 && k == efr) ? 1'b0 : 1'b1);
        end
        for (int i = 0; i < surplus + extra; i++) sb.push_back(logic'($urandom & 1));
        erri = (kind == 0) ? 32'h7fffffff : fr0 + efr * FL + err_offset(kind);

        do_reset();
        for (int j = 0; j < sb.size(); j++) begin
            int  cnt, k;
            bit  errd, done, ewr;
            int  edout;
            string rq;
            @(negedge cclk);
            din = sb[j];
            @(posedge cclk);
            #2;
            cnt  = j - (hs + 3);
            errd = (j >= erri);
            done = !errd && (cnt >= len);
            ewr  = !errd && j >= fr0 && j < fend && ((j - fr0) % FL) == FL - 1;
            if (errd) begin edout = 1; rq = "R8 dout"; end
            else if (done) begin edout = 1; rq = "R9 dout"; end
            else if (j < hs + 4) begin edout = int'(sb[j]); rq = "R1 dout hunt"; end
            else if (j < fr0) begin edout = int'(sb[j]); rq = "R2 dout header"; end
            else if (j < fend) begin edout = 1; rq = "R6 dout own"; end
            else begin edout = int'(sb[j]); rq = "R7 dout pass"; end
            chk(rq, int'(dout), edout);
            chk("R4/R5 wr", int'(wr), int'(ewr));
            if (ewr) begin
                k = (j - fr0) / FL;
                chk("R5 waddr", int'(waddr), k);
                chk("R4/R5 wdata", int'(wdata), int'(fdata[k]));
            end
            chk("R4/R8 init_n", int'(init_n), int'(!errd));
            chk("R3/R9 startup", int'(startup), int'(done));
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        run(5, 1'b0, 6, 4, 0, 0);
        run(2, 1'b1, 0, 5, 0, 0);
        run(100, 1'b0, 3, 3, 0, 0);
        run(0, 1'b1, 4, 2, 1, 1);
        run(7, 1'b0, 4, 2, 2, 2);
        run(3, 1'b0, 4, 2, 3, 0);
        run(4, 1'b0, 4, 2, 3, NF - 1);
        for (int r = 0; r < 10; r++)
            run($urandom % 20, 1'($urandom & 1), $urandom % 30, 3, $urandom % 4, $urandom % NF);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge cclk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule